// File: doc/BRIEF.md
# Clockless Strobe Handshake Link (Master and Slave)

This block joins a requesting master to a responding slave over a bus that carries no clock. Completion depends only on the order of two active-low strobes. The master raises a request by driving an address and pulling its request strobe low. The slave watches for that strobe, waits a programmable number of its own cycles, places read data on the bus and then pulls its reply strobe low. When the master sees the reply, it latches the data and lets go of its request strobe. The slave then takes its data off the bus and lets go of the reply strobe. A new request can start only once the reply strobe is high again.

Each side is a synchronous state machine with its own clock and reset. The strobe that comes from the other side passes through a two-stage synchronizer before either machine acts on it, so the two clocks need not be related. The programmable slave delay stands in for a device whose response time cannot be predicted. An optional master-side cycle counter ends a request that receives no reply and reports it as a timeout.

Top module: `hs_async_link`

## Requirements
- R1: While either reset is low, and on the first sample after it, the outputs are idle: `msyn_n`=1, `ssyn_n`=1, `bus_oe`=0, `busy`=0, `done`=0, `timeout_err`=0 and `rd_data`=0.
- R2: When `start` is high in a cycle where the master is idle, `msyn_n` goes low at that clock edge and `bus_addr` shows `req_addr`. `bus_addr` holds that value for as long as `msyn_n` stays low.
- R3: The slave drives `bus_data` (with `bus_oe`=1) with `dev_data` for the captured `dev_addr` at least one cycle before it pulls `ssyn_n` low. With both clocks equal, `ssyn_n` falls exactly `slv_latency`+5 cycles after `msyn_n` falls.
- R4: The master releases `msyn_n` only after it sees the synchronized `ssyn_n` low. At that edge it copies `bus_data` into `rd_data` and pulses `done` for one cycle. With equal clocks, this happens `slv_latency`+8 cycles after `msyn_n` fell.
- R5: The slave releases `ssyn_n` only after it sees `msyn_n` high. It drops `bus_oe` at least one cycle before `ssyn_n` rises.
- R6: A `start` that arrives while the master is busy, including the period when it is waiting for `ssyn_n` to return high, is ignored. No new request begins and `bus_addr` keeps its value.
- R7: If `timeout_lim` is nonzero and no reply has been seen after `timeout_lim` cycles of waiting, `timeout_err` pulses for one cycle and `msyn_n` is released at that same edge. In that case `done` stays low and `rd_data` is unchanged. A reply seen on the final cycle takes priority, so with equal clocks the request times out when `timeout_lim` ≤ `slv_latency`+7. A `timeout_lim` of 0 turns the counter off.
- R8: `done` and `timeout_err` are never high together.
- R9: If `msyn_n` is released while the slave is still counting its delay, the slave returns to idle without asserting `ssyn_n`. With equal clocks, this happens when `timeout_lim` ≤ `slv_latency`+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_m | input | 1 | Master clock |
| rst_m_n | input | 1 | Master synchronous reset, active low |
| clk_s | input | 1 | Slave clock |
| rst_s_n | input | 1 | Slave synchronous reset, active low |
| start | input | 1 | Request a read (master domain) |
| req_addr | input | AW | Address of the requested read |
| timeout_lim | input | TW | Reply wait limit in master cycles, 0 disables |
| slv_latency | input | LW | Slave delay in slave cycles before data is driven |
| dev_data | input | DW | Data the attached device returns for `dev_addr` |
| dev_addr | output | AW | Address the slave captured for the device |
| busy | output | 1 | Master is not idle |
| done | output | 1 | One-cycle pulse when a read completes |
| timeout_err | output | 1 | One-cycle pulse when a request times out |
| rd_data | output | DW | Data latched by the master |
| msyn_n | output | 1 | Request strobe, active low |
| ssyn_n | output | 1 | Reply strobe, active low |
| bus_addr | output | AW | Address on the bus |
| bus_data | output | DW | Data on the bus, 0 when not driven |
| bus_oe | output | 1 | Slave is driving `bus_data` |

## Verification
The properties assume that each reset is held for several cycles of its own clock, so that every `$past` term refers to a reset value. They also assume `timeout_lim` and `slv_latency` stay constant while a transfer is in flight. The stimulus changes these settings and `req_addr` only at falling clock edges while the master is idle, and holds both resets low for four cycles at a time. The cross-domain properties rely on the reply strobe having been high for the full synchronizer depth before the master starts, which the master's own wait-for-release state guarantees.

// File: rtl/hs_pkg.sv
// Shared state encodings for the strobe handshake link.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package hs_pkg;
    typedef enum logic [1:0] {
        M_IDLE,
        M_WAIT,
        M_RELEASE
    } mst_state_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LAT,
        S_DRIVE,
        S_HOLD,
        S_REL
    } slv_state_t;
endpackage

// File: rtl/hs_sync.sv
// Multi-stage synchronizer for one strobe entering a clock domain.
// Assumes: STAGES >= 2; RST_VAL is the idle level of the strobe.
module hs_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // shift the incoming level through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/hs_master.sv
// Requesting side: raises the request strobe with an address, waits for the
// synchronized reply, latches data, releases, then waits for the reply to clear.
// Assumes: ssyn_s is already synchronized to clk; timeout_lim is static per transfer.
module hs_master
    import hs_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 16,
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] req_addr,
    input  logic [TW-1:0] timeout_lim,
    input  logic          ssyn_s,
    input  logic [DW-1:0] bus_data,
    output logic          msyn_n,
    output logic [AW-1:0] bus_addr,
    output logic          busy,
    output logic          done,
    output logic          timeout_err,
    output logic [DW-1:0] rd_data
);
    mst_state_t    state;
    logic [TW-1:0] wait_cnt;
    logic          limit_hit;

    // the counter is disabled when the limit is zero
    assign limit_hit = (timeout_lim != '0) && (wait_cnt == timeout_lim - TW'(1));
    assign busy      = (state != M_IDLE);

    // request sequencing, reply wait and timeout
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= M_IDLE;
            msyn_n      <= 1'b1;
            bus_addr    <= '0;
            wait_cnt    <= '0;
            done        <= 1'b0;
            timeout_err <= 1'b0;
            rd_data     <= '0;
        end else begin
            done        <= 1'b0;
            timeout_err <= 1'b0;
            case (state)
                M_IDLE: begin
                    if (start && ssyn_s) begin
                        bus_addr <= req_addr;
                        msyn_n   <= 1'b0;
                        wait_cnt <= '0;
                        state    <= M_WAIT;
                    end
                end
                M_WAIT: begin
                    if (!ssyn_s) begin
                        rd_data <= bus_data;
                        done    <= 1'b1;
                        msyn_n  <= 1'b1;
                        state   <= M_RELEASE;
                    end else if (limit_hit) begin
                        timeout_err <= 1'b1;
                        msyn_n      <= 1'b1;
                        state       <= M_RELEASE;
                    end else begin
                        wait_cnt <= wait_cnt + TW'(1);
                    end
                end
                M_RELEASE: begin
                    if (ssyn_s) state <= M_IDLE;
                end
                default: state <= M_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/hs_slave.sv
// Responding side: on a synchronized request, captures the address, waits the
// programmed delay, drives data, asserts the reply, then undoes both in order.
// Assumes: msyn_s is already synchronized; bus_addr is stable while the request is low.
module hs_slave
    import hs_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 16,
    parameter int LW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          msyn_s,
    input  logic [AW-1:0] bus_addr,
    input  logic [LW-1:0] slv_latency,
    input  logic [DW-1:0] dev_data,
    output logic [AW-1:0] dev_addr,
    output logic [DW-1:0] bus_data,
    output logic          bus_oe,
    output logic          ssyn_n
);
    slv_state_t    state;
    logic [LW-1:0] lat_cnt;

    // response sequencing: delay, drive, reply, release
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            lat_cnt  <= '0;
            dev_addr <= '0;
            bus_data <= '0;
            bus_oe   <= 1'b0;
            ssyn_n   <= 1'b1;
        end else begin
            case (state)
                S_IDLE: begin
                    if (!msyn_s) begin
                        dev_addr <= bus_addr;
                        lat_cnt  <= '0;
                        state    <= S_LAT;
                    end
                end
                S_LAT: begin
                    if (msyn_s) begin
                        state <= S_IDLE;
                    end else if (lat_cnt == slv_latency) begin
                        bus_data <= dev_data;
                        bus_oe   <= 1'b1;
                        state    <= S_DRIVE;
                    end else begin
                        lat_cnt <= lat_cnt + LW'(1);
                    end
                end
                S_DRIVE: begin
                    ssyn_n <= 1'b0;
                    state  <= S_HOLD;
                end
                S_HOLD: begin
                    if (msyn_s) begin
                        bus_oe   <= 1'b0;
                        bus_data <= '0;
                        state    <= S_REL;
                    end
                end
                S_REL: begin
                    ssyn_n <= 1'b1;
                    state  <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/hs_async_link.sv
// Top: master and slave joined by the two strobes, each strobe synchronized
// into the receiving domain.
// Assumes: clocks may be unrelated; each reset is synchronous to its own clock.
module hs_async_link #(
    parameter int AW          = 8,
    parameter int DW          = 16,
    parameter int LW          = 4,
    parameter int TW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk_m,
    input  logic          rst_m_n,
    input  logic          clk_s,
    input  logic          rst_s_n,
    input  logic          start,
    input  logic [AW-1:0] req_addr,
    input  logic [TW-1:0] timeout_lim,
    input  logic [LW-1:0] slv_latency,
    input  logic [DW-1:0] dev_data,
    output logic [AW-1:0] dev_addr,
    output logic          busy,
    output logic          done,
    output logic          timeout_err,
    output logic [DW-1:0] rd_data,
    output logic          msyn_n,
    output logic          ssyn_n,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_data,
    output logic          bus_oe
);
    logic msyn_s;
    logic ssyn_s;

    hs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_reply (
        .clk(clk_m), .rst_n(rst_m_n), .d(ssyn_n), .q(ssyn_s)
    );

    hs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_req (
        .clk(clk_s), .rst_n(rst_s_n), .d(msyn_n), .q(msyn_s)
    );

    hs_master #(.AW(AW), .DW(DW), .TW(TW)) u_mst (
        .clk(clk_m), .rst_n(rst_m_n), .start(start), .req_addr(req_addr),
        .timeout_lim(timeout_lim), .ssyn_s(ssyn_s), .bus_data(bus_data),
        .msyn_n(msyn_n), .bus_addr(bus_addr), .busy(busy), .done(done),
        .timeout_err(timeout_err), .rd_data(rd_data)
    );

    hs_slave #(.AW(AW), .DW(DW), .LW(LW)) u_slv (
        .clk(clk_s), .rst_n(rst_s_n), .msyn_s(msyn_s), .bus_addr(bus_addr),
        .slv_latency(slv_latency), .dev_data(dev_data), .dev_addr(dev_addr),
        .bus_data(bus_data), .bus_oe(bus_oe), .ssyn_n(ssyn_n)
    );
endmodule

// File: rtl/hs_link_chk.sv
// Protocol checker for the strobe handshake; bound into the top module.
// Assumes: resets held several cycles before release.
module hs_link_chk #(
    parameter int AW = 8
) (
    input logic          clk_m,
    input logic          rst_m_n,
    input logic          clk_s,
    input logic          rst_s_n,
    input logic          msyn_n,
    input logic          ssyn_n,
    input logic          bus_oe,
    input logic [AW-1:0] bus_addr,
    input logic          done,
    input logic          timeout_err
);
    AST_ADDR_STABLE: assert property (@(posedge clk_m) disable iff (!rst_m_n)
        (!msyn_n && $past(!msyn_n)) |-> $stable(bus_addr)); // R2

    AST_DATA_BEFORE_REPLY: assert property (@(posedge clk_s) disable iff (!rst_s_n)
        $fell(ssyn_n) |-> (bus_oe && $past(bus_oe))); // R3

    AST_RELEASE_HAS_CAUSE: assert property (@(posedge clk_m) disable iff (!rst_m_n)
        $rose(msyn_n) |-> (done || timeout_err)); // R4

    AST_DONE_SINGLE: assert property (@(posedge clk_m) disable iff (!rst_m_n)
        done |=> !done); // R4

    AST_DATA_OFF_FIRST: assert property (@(posedge clk_s) disable iff (!rst_s_n)
        $rose(ssyn_n) |-> (!bus_oe && $past(!bus_oe))); // R5

    AST_NO_EARLY_START: assert property (@(posedge clk_m) disable iff (!rst_m_n)
        $fell(msyn_n) |-> ssyn_n); // R6

    AST_ONE_OUTCOME: assert property (@(posedge clk_m) disable iff (!rst_m_n)
        $onehot0({done, timeout_err})); // R8
endmodule

bind hs_async_link hs_link_chk #(.AW(AW)) u_chk (
    .clk_m(clk_m), .rst_m_n(rst_m_n), .clk_s(clk_s), .rst_s_n(rst_s_n),
    .msyn_n(msyn_n), .ssyn_n(ssyn_n), .bus_oe(bus_oe), .bus_addr(bus_addr),
    .done(done), .timeout_err(timeout_err)
);

// File: tb/sim_hs_async_link.sv
module sim_hs_async_link;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam int LW = 4;
    localparam int TW = 8;
    localparam int NVEC = 7;

    // vector: {addr[8], latency[4], timeout limit[8], expect timeout[1]}
    localparam logic [20:0] VEC [NVEC] = '{
        {8'h3C, 4'd0,  8'd0,  1'b0},
        {8'hA5, 4'd3,  8'd0,  1'b0},
        {8'h00, 4'd15, 8'd0,  1'b0},
        {8'hFF, 4'd4,  8'd12, 1'b0},
        {8'h5A, 4'd4,  8'd11, 1'b1},
        {8'h81, 4'd10, 8'd2,  1'b1},
        {8'h42, 4'd1,  8'd50, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [TW-1:0] tlim = '0;
    logic [LW-1:0] lat = '0;
    logic [DW-1:0] dev_data;
    logic [AW-1:0] dev_addr;
    logic          busy, done, timeout_err, msyn_n, ssyn_n, bus_oe;
    logic [DW-1:0] rd_data, bus_data;
    logic [AW-1:0] bus_addr;

    int            checks = 0;
    int            fails = 0;
    logic [DW-1:0] last_rd = '0;

    always #5 clk = ~clk;

    // device model: data is the inverted address above the address
    assign dev_data = {~dev_addr, dev_addr};

    hs_async_link #(.AW(AW), .DW(DW), .LW(LW), .TW(TW)) u0 (
        .clk_m(clk), .rst_m_n(rst_n), .clk_s(clk), .rst_s_n(rst_n),
        .start(start), .req_addr(req_addr), .timeout_lim(tlim),
        .slv_latency(lat), .dev_data(dev_data), .dev_addr(dev_addr),
        .busy(busy), .done(done), .timeout_err(timeout_err),
        .rd_data(rd_data), .msyn_n(msyn_n), .ssyn_n(ssyn_n),
        .bus_addr(bus_addr), .bus_data(bus_data), .bus_oe(bus_oe)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic chk_idle(input string tag);
        chk({tag, " R1 msyn_n"}, 32'(msyn_n), 32'd1);
        chk({tag, " R1 ssyn_n"}, 32'(ssyn_n), 32'd1);
        chk({tag, " R1 bus_oe"}, 32'(bus_oe), 32'd0);
        chk({tag, " R1 busy"}, 32'(busy), 32'd0);
        chk({tag, " R1 done"}, 32'(done), 32'd0);
        chk({tag, " R1 timeout_err"}, 32'(timeout_err), 32'd0);
        chk({tag, " R1 rd_data"}, 32'(rd_data), 32'd0);
    endtask

    // wait until master idle and reply released; check release ordering (R5)
    task automatic drain(inout int sl, input int base);
        int   guard = 0;
        logic p_ssyn = ssyn_n;
        logic p_oe = bus_oe;
        while ((busy || !ssyn_n || bus_oe) && guard < 400) begin
            @(negedge clk);
            guard++;
            if (!ssyn_n && sl < 0) sl = base + guard;
            if (ssyn_n && !p_ssyn) begin
                chk("R5 data off before reply release", 32'(p_oe), 32'd0);
                chk("R5 request high at reply release", 32'(msyn_n), 32'd1);
            end
            p_ssyn = ssyn_n;
            p_oe   = bus_oe;
        end
    endtask

    task automatic run_xfer(input logic [7:0] a, input logic [3:0] l,
                            input logic [7:0] t, input bit e);
        int n = 0;
        int sl = -1;
        @(negedge clk);
        req_addr = a; lat = l; tlim = t; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R2 request strobe low", 32'(msyn_n), 32'd0);
        chk("R2 bus address", 32'(bus_addr), 32'(a));
        while (!(done || timeout_err) && n < 400) begin
            @(negedge clk);
            n++;
            if (!ssyn_n && sl < 0) sl = n;
        end
        chk("R4 R7 request released at outcome", 32'(msyn_n), 32'd1);
        if (!e) begin
            chk("R3 reply delay", 32'(sl), 32'(int'(l) + 5));
            chk("R4 done cycle", 32'(n), 32'(int'(l) + 8));
            chk("R4 read data", 32'(rd_data), 32'({~a, a}));
            chk("R8 no timeout with done", 32'(timeout_err), 32'd0);
            last_rd = {~a, a};
        end else begin
            chk("R7 timeout cycle", 32'(n), 32'(t));
            chk("R7 no done", 32'(done), 32'd0);
            chk("R7 read data held", 32'(rd_data), 32'(last_rd));
        end
        drain(sl, n);
        if (e && (int'(t) <= int'(l) + 1))
            chk("R9 slave aborted without reply", 32'(sl), 32'hFFFF_FFFF);
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int sl;
        repeat (4) @(negedge clk);
        chk_idle("in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("after reset");

        for (int i = 0; i < NVEC; i++)
            run_xfer(VEC[i][20:13], VEC[i][12:9], VEC[i][8:1], VEC[i][0]);

        // R6: start during a transfer and during the release wait
        @(negedge clk);
        req_addr = 8'h11; lat = 4'd6; tlim = '0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        req_addr = 8'h99; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R6 address kept while busy", 32'(bus_addr), 32'h11);
        while (!done) @(negedge clk);
        chk("R6 read data of first request", 32'(rd_data), 32'({~8'h11, 8'h11}));
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        sl = -1;
        drain(sl, 0);
        repeat (6) @(negedge clk);
        chk("R6 no new request", 32'(msyn_n), 32'd1);
        chk("R6 address unchanged", 32'(bus_addr), 32'h11);
        last_rd = {~8'h11, 8'h11};

        // R1: reset while the reply is asserted
        @(negedge clk);
        req_addr = 8'h2D; lat = 4'd0; tlim = '0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (6) @(negedge clk);
        chk("R3 reply asserted before reset", 32'(ssyn_n), 32'd0);
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        chk_idle("mid-transfer reset");
        rst_n = 1'b1;
        last_rd = '0;
        run_xfer(8'h77, 4'd2, 8'd0, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule